// File: doc/BRIEF.md
# Dual-Buffer Flash Operation Scheduler

This block is the admission and busy-tracking core of a serial flash memory that has two page-sized SRAM buffers in front of a main array. It receives already-decoded operation requests, each made of an operation code, a buffer select, a page address and, for byte accesses, a byte offset and a data byte. For every request it decides in one clock whether the operation may start. It then either performs it at once or runs a self-timed array operation whose length is set by a parameter. The main array and both buffers are small behavioural memories inside the block.

Operations fall into two classes. Array operations touch the main array, and only one of them may run at a time. Buffer-only operations (buffer read, buffer write, status read) are still admitted while an array operation runs, as long as they do not touch the buffer that operation holds. This lets a host fill one buffer while the other buffer is being written into the array. A write-protect input guards the low pages against program and erase. The active-low reset aborts a running operation before it has any effect.

Top module: `dualBufferOpScheduler`

## Requirements
- R1: While reset is low and after it is released, readyBusyN is 1, reqAccept, reqReject and respValid are 0, and a first status read returns 8'h00. The status byte has busy in bit 0, the sticky error flag in bit 1 and the compare mismatch flag in bit 2; all other bits read 0.
- R2: Operation codes on reqOp are: 1 buffer read, 2 buffer write, 3 status read, 4 page read, 5 page-to-buffer transfer, 6 page-to-buffer compare, 7 program page from buffer with erase, 8 program page from buffer without erase, 9 page erase, 10 block erase, 11 page rewrite. A request sampled with reqValid high is answered one cycle later by a one-cycle pulse on exactly one of reqAccept or reqReject. Any other code gets neither pulse and has no effect. Accepted codes 1, 3 and 4 put their data on respData with respValid high in that same cycle.
- R3: An accepted code 5 to 11 drives readyBusyN low from the cycle after acceptance for exactly BUSY_CYCLES cycles. Status bit 0 reads 1 during that time.
- R4: A request with code 4 to 11 that arrives while busy is rejected.
- R5: While busy, a buffer read or write to the buffer not held by the running operation is accepted and performed.
- R6: While an operation with code 5, 6, 7, 8 or 11 runs, a buffer read or write to the buffer it named is rejected. Page erase and block erase hold no buffer.
- R7: When wpN is 0, codes 7 to 11 aimed at a page below PROT_PAGES are rejected. For block erase this uses the page given in the request.
- R8: Every rejection sets status bit 1, which stays set until reset. A rejected request changes neither the array nor any buffer.
- R9: When a compare completes, status bit 2 is set to 1 if any byte of the page differs from the named buffer, and cleared to 0 if all bytes match.
- R10: When it completes, code 7 copies the buffer into the page, code 8 ANDs the buffer into the page bytewise, code 9 sets every byte of the page to 8'hFF, and code 10 sets every byte of the BLOCK_PAGES-aligned block that holds the page to 8'hFF.
- R11: When it completes, code 5 or code 11 copies the page into the named buffer and leaves the page unchanged.
- R12: Driving rstN low during a timed operation aborts it with no effect on the array or buffers, clears the status flags and holds the block idle (readyBusyN 1, no accept) for as long as rstN stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset and abort |
| wpN | input | 1 | Write protect, low guards pages below PROT_PAGES |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 4 | Operation code |
| reqBuf | input | 1 | Buffer select |
| reqPage | input | PAGE_W | Page address |
| reqByte | input | BYTE_W | Byte offset for byte accesses |
| reqData | input | 8 | Write data for buffer write |
| reqAccept | output | 1 | Request admitted (one cycle after request) |
| reqReject | output | 1 | Request refused (one cycle after request) |
| respValid | output | 1 | Read data valid |
| respData | output | 8 | Read data from buffer, array or status |
| readyBusyN | output | 1 | High when ready, low during a timed operation |

## Verification
Requests are issued one every other cycle, including long runs of buffer traffic placed inside a single timed operation. This shows whether admission depends on which buffer the running operation holds, rather than only on the busy flag. The program operations use a buffer pattern whose AND with the old page differs from both inputs, which separates program-with-erase from program-without-erase. Compares are run once with equal and once with unequal contents, so the mismatch bit must change in both directions. Protected and unprotected pages on either side of PROT_PAGES, and a reset dropped in the middle of a program, show whether a guarded or aborted operation leaves the array untouched.

// File: rtl/schedPkg.sv
package schedPkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_BUF_RD      = 4'd1,
    OP_BUF_WR      = 4'd2,
    OP_STAT_RD     = 4'd3,
    OP_PAGE_RD     = 4'd4,
    OP_XFER        = 4'd5,
    OP_CMP         = 4'd6,
    OP_PROG_ERASE  = 4'd7,
    OP_PROG_KEEP   = 4'd8,
    OP_PAGE_ERASE  = 4'd9,
    OP_BLOCK_ERASE = 4'd10,
    OP_REWRITE     = 4'd11
  } opCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWr;
    logic bufRd;
    logic statRd;
    logic arrRd;
    logic doneXfer;
    logic doneCmp;
    logic doneProgErase;
    logic doneProgKeep;
    logic donePageErase;
    logic doneBlockErase;
  } strobe_t;

  function automatic logic isKnown(logic [3:0] op);
    return (op >= OP_BUF_RD) && (op <= OP_REWRITE);
  endfunction

  function automatic logic isArrayOp(logic [3:0] op);
    return (op >= OP_PAGE_RD) && (op <= OP_REWRITE);
  endfunction

  function automatic logic isTimed(logic [3:0] op);
    return (op >= OP_XFER) && (op <= OP_REWRITE);
  endfunction

  function automatic logic isBufAccess(logic [3:0] op);
    return (op == OP_BUF_RD) || (op == OP_BUF_WR);
  endfunction

  function automatic logic locksBuffer(logic [3:0] op);
    return (op == OP_XFER) || (op == OP_CMP) || (op == OP_PROG_ERASE) ||
           (op == OP_PROG_KEEP) || (op == OP_REWRITE);
  endfunction

  function automatic logic isGuarded(logic [3:0] op);
    return (op >= OP_PROG_ERASE) && (op <= OP_REWRITE);
  endfunction

endpackage

// File: rtl/schedCtrl.sv
module schedCtrl
  import schedPkg::*;
#(
  parameter int PAGE_W      = 9,
  parameter int BYTE_W      = 2,
  parameter int PROT_PAGES  = 256,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic              reqBuf,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [BYTE_W-1:0] reqByte,
  input  logic [7:0]        reqData,
  input  logic              cmpMismatch,
  output strobe_t           st,
  output logic              nowBuf,
  output logic [PAGE_W-1:0] nowPage,
  output logic [BYTE_W-1:0] nowByte,
  output logic [7:0]        nowData,
  output logic              runBuf,
  output logic [PAGE_W-1:0] runPage,
  output logic [7:0]        statByte,
  output logic              reqAccept,
  output logic              reqReject,
  output logic              readyBusyN
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [PAGE_W:0]  PROT_LIM = (PAGE_W + 1)'(PROT_PAGES);

  logic              busyQ;
  logic [CNT_W-1:0]  cntQ;
  logic [3:0]        runOpQ;
  logic              runBufQ;
  logic [PAGE_W-1:0] runPageQ;
  logic              errSticky;
  logic              mismatchQ;

  logic known, lockHit, protHit, arrayClash, rejNow, accNow, finish;

  always_comb begin
    known      = isKnown(reqOp);
    arrayClash = busyQ && isArrayOp(reqOp);
    lockHit    = busyQ && locksBuffer(runOpQ) && isBufAccess(reqOp) && (reqBuf == runBufQ);
    protHit    = !wpN && isGuarded(reqOp) && ({1'b0, reqPage} < PROT_LIM);
    rejNow     = reqValid && known && (arrayClash || lockHit || protHit);
    accNow     = reqValid && known && !rejNow;
    finish     = busyQ && (cntQ == '0);
  end

  always_comb begin
    st.bufWr          = accNow && (reqOp == OP_BUF_WR);
    st.bufRd          = accNow && (reqOp == OP_BUF_RD);
    st.statRd         = accNow && (reqOp == OP_STAT_RD);
    st.arrRd          = accNow && (reqOp == OP_PAGE_RD);
    st.doneXfer       = finish && ((runOpQ == OP_XFER) || (runOpQ == OP_REWRITE));
    st.doneCmp        = finish && (runOpQ == OP_CMP);
    st.doneProgErase  = finish && (runOpQ == OP_PROG_ERASE);
    st.doneProgKeep   = finish && (runOpQ == OP_PROG_KEEP);
    st.donePageErase  = finish && (runOpQ == OP_PAGE_ERASE);
    st.doneBlockErase = finish && (runOpQ == OP_BLOCK_ERASE);
  end

  assign nowBuf     = reqBuf;
  assign nowPage    = reqPage;
  assign nowByte    = reqByte;
  assign nowData    = reqData;
  assign runBuf     = runBufQ;
  assign runPage    = runPageQ;
  assign statByte   = {5'b0, mismatchQ, errSticky, busyQ};
  assign readyBusyN = !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      cntQ      <= '0;
      runOpQ    <= OP_NONE;
      runBufQ   <= 1'b0;
      runPageQ  <= '0;
      errSticky <= 1'b0;
      mismatchQ <= 1'b0;
      reqAccept <= 1'b0;
      reqReject <= 1'b0;
    end else begin
      reqAccept <= accNow;
      reqReject <= rejNow;
      if (rejNow) errSticky <= 1'b1;
      if (finish) begin
        busyQ <= 1'b0;
        if (runOpQ == OP_CMP) mismatchQ <= cmpMismatch;
      end else if (busyQ) begin
        cntQ <= cntQ - 1'b1;
      end
      if (accNow && isTimed(reqOp)) begin
        busyQ    <= 1'b1;
        cntQ     <= CNT_LOAD;
        runOpQ   <= reqOp;
        runBufQ  <= reqBuf;
        runPageQ <= reqPage;
      end
    end
  end

endmodule

// File: rtl/schedData.sv
module schedData
  import schedPkg::*;
#(
  parameter int PAGES       = 512,
  parameter int PAGE_BYTES  = 4,
  parameter int BLOCK_PAGES = 8,
  parameter int PAGE_W      = 9,
  parameter int BYTE_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              nowBuf,
  input  logic [PAGE_W-1:0] nowPage,
  input  logic [BYTE_W-1:0] nowByte,
  input  logic [7:0]        nowData,
  input  logic              runBuf,
  input  logic [PAGE_W-1:0] runPage,
  input  logic [7:0]        statByte,
  output logic              respValid,
  output logic [7:0]        respData,
  output logic              cmpMismatch
);

  localparam int ARR_DEPTH = PAGES * PAGE_BYTES;
  localparam int BUF_DEPTH = 2 * PAGE_BYTES;
  localparam int BLK_W     = $clog2(BLOCK_PAGES);

  logic [7:0] arrMem [ARR_DEPTH];
  logic [7:0] bufMem [BUF_DEPTH];

  logic [PAGE_W-1:0]     blockBase;
  logic [PAGE_BYTES-1:0] byteDiff;

  assign blockBase = {runPage[PAGE_W-1:BLK_W], {BLK_W{1'b0}}};

  // per-byte comparison of the running page against its buffer
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cmp
    assign byteDiff[g] = arrMem[{runPage, BYTE_W'(g)}] != bufMem[{runBuf, BYTE_W'(g)}];
  end
  assign cmpMismatch = |byteDiff;

  // memory updates: immediate buffer write plus timed-operation completion
  always_ff @(posedge clk) begin
    if (st.bufWr) bufMem[{nowBuf, nowByte}] <= nowData;
    if (st.doneXfer) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        bufMem[{runBuf, BYTE_W'(b)}] <= arrMem[{runPage, BYTE_W'(b)}];
    end
    if (st.doneProgErase) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        arrMem[{runPage, BYTE_W'(b)}] <= bufMem[{runBuf, BYTE_W'(b)}];
    end
    if (st.doneProgKeep) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        arrMem[{runPage, BYTE_W'(b)}] <= arrMem[{runPage, BYTE_W'(b)}] &
                                          bufMem[{runBuf, BYTE_W'(b)}];
    end
    if (st.donePageErase) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        arrMem[{runPage, BYTE_W'(b)}] <= 8'hFF;
    end
    if (st.doneBlockErase) begin
      for (int p = 0; p < BLOCK_PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          arrMem[{blockBase | PAGE_W'(p), BYTE_W'(b)}] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= 8'h00;
    end else begin
      respValid <= st.bufRd || st.statRd || st.arrRd;
      if (st.statRd)      respData <= statByte;
      else if (st.bufRd)  respData <= bufMem[{nowBuf, nowByte}];
      else if (st.arrRd)  respData <= arrMem[{nowPage, nowByte}];
    end
  end

endmodule

// File: rtl/dualBufferOpScheduler.sv
module dualBufferOpScheduler
  import schedPkg::*;
#(
  parameter int PAGES       = 512,
  parameter int PAGE_BYTES  = 4,
  parameter int BLOCK_PAGES = 8,
  parameter int PROT_PAGES  = 256,
  parameter int BUSY_CYCLES = 8,
  parameter int PAGE_W      = $clog2(PAGES),
  parameter int BYTE_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic              reqBuf,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [BYTE_W-1:0] reqByte,
  input  logic [7:0]        reqData,
  output logic              reqAccept,
  output logic              reqReject,
  output logic              respValid,
  output logic [7:0]        respData,
  output logic              readyBusyN
);

  strobe_t           st;
  logic              nowBuf, runBuf, cmpMismatch;
  logic [PAGE_W-1:0] nowPage, runPage;
  logic [BYTE_W-1:0] nowByte;
  logic [7:0]        nowData, statByte;

  schedCtrl #(
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W),
    .PROT_PAGES(PROT_PAGES), .BUSY_CYCLES(BUSY_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wpN(wpN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBuf(reqBuf), .reqPage(reqPage), .reqByte(reqByte), .reqData(reqData),
    .cmpMismatch(cmpMismatch), .st(st), .nowBuf(nowBuf), .nowPage(nowPage),
    .nowByte(nowByte), .nowData(nowData), .runBuf(runBuf), .runPage(runPage),
    .statByte(statByte), .reqAccept(reqAccept), .reqReject(reqReject),
    .readyBusyN(readyBusyN)
  );

  schedData #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .BLOCK_PAGES(BLOCK_PAGES),
    .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .st(st), .nowBuf(nowBuf), .nowPage(nowPage),
    .nowByte(nowByte), .nowData(nowData), .runBuf(runBuf), .runPage(runPage),
    .statByte(statByte), .respValid(respValid), .respData(respData),
    .cmpMismatch(cmpMismatch)
  );

endmodule

// File: rtl/schedChecks.sv
module schedChecks
  import schedPkg::*;
#(
  parameter int PAGE_W      = 9,
  parameter int PROT_PAGES  = 256,
  parameter int BUSY_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpN,
  input logic              reqValid,
  input logic [3:0]        reqOp,
  input logic [PAGE_W-1:0] reqPage,
  input logic              reqAccept,
  input logic              reqReject,
  input logic              readyBusyN,
  input logic              errFlag
);

  localparam logic [PAGE_W:0] PROT_LIM = (PAGE_W + 1)'(PROT_PAGES);

  int busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           busyRun <= 0;
    else if (readyBusyN) busyRun <= 0;
    else                 busyRun <= busyRun + 1;
  end

  // R2: never both answers for one request
  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(reqAccept && reqReject));

  // R3: the busy window never exceeds its programmed length
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= BUSY_CYCLES);

  // R4: array request while busy is refused
  p_array_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !readyBusyN && isArrayOp(reqOp)) |=> (reqReject && !reqAccept));

  // R7: guarded page with protection active is refused
  p_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !wpN && isGuarded(reqOp) && ({1'b0, reqPage} < PROT_LIM)) |=> reqReject);

  // R8: a refusal leaves the error flag set, and it stays set
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> errFlag);
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

bind dualBufferOpScheduler schedChecks #(
  .PAGE_W(PAGE_W), .PROT_PAGES(PROT_PAGES), .BUSY_CYCLES(BUSY_CYCLES)
) i_checks (
  .clk(clk), .rstN(rstN), .wpN(wpN), .reqValid(reqValid), .reqOp(reqOp),
  .reqPage(reqPage), .reqAccept(reqAccept), .reqReject(reqReject),
  .readyBusyN(readyBusyN), .errFlag(i_ctrl.errSticky)
);

// File: tb/test_dualBufferOpScheduler.sv
`timescale 1ns/1ps
module test_dualBufferOpScheduler;

  localparam int PAGES = 512, PB = 4, BLK = 8, PROT = 256, BUSY = 24;

  logic       clk = 1'b0, rstN = 1'b0, wpN = 1'b1, reqValid = 1'b0, reqBuf = 1'b0;
  logic [3:0] reqOp = 4'd0;
  logic [8:0] reqPage = '0;
  logic [1:0] reqByte = '0;
  logic [7:0] reqData = '0, respData;
  logic       reqAccept, reqReject, respValid, readyBusyN;

  always #10 clk = ~clk;

  dualBufferOpScheduler #(
    .PAGES(PAGES), .PAGE_BYTES(PB), .BLOCK_PAGES(BLK),
    .PROT_PAGES(PROT), .BUSY_CYCLES(BUSY)
  ) i_dualBufferOpScheduler (
    .clk(clk), .rstN(rstN), .wpN(wpN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBuf(reqBuf), .reqPage(reqPage), .reqByte(reqByte), .reqData(reqData),
    .reqAccept(reqAccept), .reqReject(reqReject), .respValid(respValid),
    .respData(respData), .readyBusyN(readyBusyN)
  );

  int    nChecks = 0, nFails = 0;
  bit    finished = 0;
  string curReq = "R2";

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mArr [PAGES*PB];
  logic [7:0] mBufs [2][PB];
  bit   mBusy, mErr, mMis, mRunBuf;
  int   mCnt, mOp, mPage;
  bit   eAcc, eRej, eRV;
  logic [7:0] eRD;

  function automatic bit holdsBuf(int op);
    return op == 5 || op == 6 || op == 7 || op == 8 || op == 11;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mErr = 0; mMis = 0; mCnt = 0; mOp = 0;
      eAcc = 0; eRej = 0; eRV = 0;
    end else begin
      int op, pg, by;
      bit known, rej, acc, preBusy;
      logic [7:0] stat;
      op = reqOp; pg = reqPage; by = reqByte;
      preBusy = mBusy;
      stat = {5'b0, mMis, mErr, mBusy};
      known = reqValid && op >= 1 && op <= 11;
      rej = known && ((preBusy && op >= 4) ||
                      (preBusy && holdsBuf(mOp) && (op == 1 || op == 2) && reqBuf == mRunBuf) ||
                      (!wpN && op >= 7 && pg < PROT));
      acc = known && !rej;
      if (preBusy) begin
        if (mCnt == 0) begin
          mBusy = 0;
          case (mOp)
            5, 11: for (int b = 0; b < PB; b++) mBufs[mRunBuf][b] = mArr[mPage*PB+b];
            6: begin
              mMis = 0;
              for (int b = 0; b < PB; b++) if (mArr[mPage*PB+b] != mBufs[mRunBuf][b]) mMis = 1;
            end
            7: for (int b = 0; b < PB; b++) mArr[mPage*PB+b] = mBufs[mRunBuf][b];
            8: for (int b = 0; b < PB; b++) mArr[mPage*PB+b] = mArr[mPage*PB+b] & mBufs[mRunBuf][b];
            9: for (int b = 0; b < PB; b++) mArr[mPage*PB+b] = 8'hFF;
            10: for (int p = (mPage/BLK)*BLK; p < (mPage/BLK)*BLK + BLK; p++)
                  for (int b = 0; b < PB; b++) mArr[p*PB+b] = 8'hFF;
            default: ;
          endcase
        end else mCnt--;
      end
      if (rej) mErr = 1;
      eRV = 0;
      if (acc) begin
        case (op)
          1: begin eRV = 1; eRD = mBufs[reqBuf][by]; end
          2: mBufs[reqBuf][by] = reqData;
          3: begin eRV = 1; eRD = stat; end
          4: begin eRV = 1; eRD = mArr[pg*PB+by]; end
          default: begin mBusy = 1; mCnt = BUSY - 1; mOp = op; mRunBuf = reqBuf; mPage = pg; end
        endcase
      end
      eAcc = acc; eRej = rej;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({curReq, " readyBusyN"}, readyBusyN, !mBusy);
      check({curReq, " reqAccept"}, reqAccept, eAcc);
      check({curReq, " reqReject"}, reqReject, eRej);
      check({curReq, " respValid"}, respValid, eRV);
      if (eRV) check({curReq, " respData"}, respData, eRD);
    end
  end

  // ---------------- stimulus helpers ----------------
  bit lastAcc, lastRej, lastRV;
  logic [7:0] lastRD;

  task automatic issue(input int op, input bit b, input int pg, input int by, input int d);
    @(posedge clk); #1;
    reqValid = 1; reqOp = 4'(op); reqBuf = b; reqPage = 9'(pg); reqByte = 2'(by); reqData = 8'(d);
    @(posedge clk); #1;
    reqValid = 0;
    @(negedge clk);
    lastAcc = reqAccept; lastRej = reqReject; lastRV = respValid; lastRD = respData;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!readyBusyN) begin n++; @(negedge clk); end
  endtask

  task automatic readPage(input string tag, input int pg, input int by, input int exp);
    issue(4, 0, pg, by, 0);
    check({tag, " page data"}, lastRD, exp);
  endtask

  task automatic readStatus(input string tag, input int exp);
    issue(3, 0, 0, 0, 0);
    check({tag, " status"}, lastRD, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    curReq = "R1";
    repeat (3) @(posedge clk);
    check("R1 ready during reset", readyBusyN, 1);
    #1 rstN = 1;
    @(negedge clk);
    check("R1 ready", readyBusyN, 1);
    check("R1 accept", reqAccept, 0);
    check("R1 respValid", respValid, 0);
    readStatus("R1", 8'h00);

    // R10 erase and busy length
    curReq = "R3";
    issue(9, 0, 300, 0, 0);
    check("R3 erase accepted", lastAcc, 1);
    waitReady(n);
    check("R3 busy length", n, BUSY);
    curReq = "R10";
    readPage("R10 erase", 300, 2, 8'hFF);
    issue(9, 0, 301, 0, 0); waitReady(n);
    issue(10, 1, 305, 0, 0); waitReady(n);
    readPage("R10 block erase", 311, 3, 8'hFF);
    readPage("R10 block erase", 304, 0, 8'hFF);

    // R2 buffer traffic and unknown code
    curReq = "R2";
    for (int b = 0; b < PB; b++) issue(2, 0, 0, b, 8'hA0 + b);
    issue(1, 0, 0, 1, 0);
    check("R2 buffer read", lastRD, 8'hA1);
    issue(12, 0, 0, 0, 0);
    check("R2 unknown code accept", lastAcc, 0);
    check("R2 unknown code reject", lastRej, 0);

    // program from buffer 0 with traffic during busy
    curReq = "R5";
    issue(7, 0, 300, 0, 0);
    issue(2, 1, 0, 0, 8'h55);
    check("R5 other buffer write", lastAcc, 1);
    issue(1, 1, 0, 0, 0);
    check("R5 other buffer read", lastRD, 8'h55);
    curReq = "R6";
    issue(2, 0, 0, 0, 8'hEE);
    check("R6 locked write", lastRej, 1);
    issue(1, 0, 0, 0, 0);
    check("R6 locked read", lastRej, 1);
    curReq = "R4";
    issue(4, 0, 300, 0, 0);
    check("R4 page read while busy", lastRej, 1);
    issue(9, 1, 400, 0, 0);
    check("R4 erase while busy", lastRej, 1);
    curReq = "R3";
    readStatus("R3 R8 busy and error", 8'h03);
    waitReady(n);
    curReq = "R10";
    readPage("R10 program", 300, 1, 8'hA1);
    curReq = "R8";
    issue(1, 0, 0, 0, 0);
    check("R8 rejected write no effect", lastRD, 8'hA0);

    // R9 compare
    curReq = "R9";
    issue(6, 0, 300, 0, 0); waitReady(n);
    readStatus("R9 match", 8'h02);
    issue(2, 0, 0, 3, 8'h00);
    issue(6, 0, 300, 0, 0); waitReady(n);
    readStatus("R9 mismatch", 8'h06);

    // R10 program without erase
    curReq = "R10";
    issue(2, 1, 0, 0, 8'h0F); issue(2, 1, 0, 1, 8'hF0);
    issue(2, 1, 0, 2, 8'h3C); issue(2, 1, 0, 3, 8'h00);
    issue(8, 1, 300, 0, 0); waitReady(n);
    readPage("R10 and-program", 300, 1, 8'hA0);
    readPage("R10 and-program", 300, 2, 8'h20);

    // R11 transfer and rewrite
    curReq = "R11";
    issue(5, 1, 300, 0, 0); waitReady(n);
    issue(1, 1, 0, 2, 0);
    check("R11 transfer", lastRD, 8'h20);
    issue(11, 0, 300, 0, 0); waitReady(n);
    issue(1, 0, 0, 1, 0);
    check("R11 rewrite buffer", lastRD, 8'hA0);
    readPage("R11 rewrite page kept", 300, 1, 8'hA0);

    // R6 erase holds no buffer
    curReq = "R6";
    issue(9, 0, 302, 0, 0);
    issue(1, 0, 0, 1, 0);
    check("R6 erase holds no buffer", lastAcc, 1);
    waitReady(n);

    // R7 write protect
    curReq = "R7";
    issue(9, 0, 10, 0, 0); waitReady(n);
    wpN = 0;
    issue(7, 0, 10, 0, 0);
    check("R7 protected program", lastRej, 1);
    issue(9, 0, 255, 0, 0);
    check("R7 protected erase edge", lastRej, 1);
    issue(10, 0, 8, 0, 0);
    check("R7 protected block", lastRej, 1);
    issue(11, 0, 10, 0, 0);
    check("R7 protected rewrite", lastRej, 1);
    readPage("R7 R8 page kept", 10, 0, 8'hFF);
    issue(9, 0, 256, 0, 0);
    check("R7 first open page", lastAcc, 1);
    waitReady(n);
    wpN = 1;

    // R12 reset abort
    curReq = "R12";
    issue(7, 0, 301, 0, 0);
    repeat (3) @(posedge clk);
    #1 rstN = 0;
    @(negedge clk);
    check("R12 idle on abort", readyBusyN, 1);
    issue(9, 0, 303, 0, 0);
    check("R12 no accept in reset", lastAcc, 0);
    check("R12 stays idle", readyBusyN, 1);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    readPage("R12 aborted program", 301, 1, 8'hFF);
    readStatus("R12 status cleared", 8'h00);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule